// File: doc/BRIEF.md
# Adaptive Voltage Scaling Controller

This block is a closed-loop digital controller that trims a supply voltage down for as long as a replica of the critical path still beats the delay allowed by the programmed clock period. Software first loads a target period and a starting voltage code, and also sets the code limits, the step size, the margin window, and two wait counts. It then raises the enable and pulses start. The controller drives the starting code to a regulator and waits for the regulator's acknowledge and a settle interval. After that it compares the measured replica delay code with the required delay.

A measurement that is too fast by more than the margin lowers the code by one step. A measurement that is too slow raises it by one step. A measurement inside the window locks the loop. While locked, a slow measurement causes an immediate step up. A fast drift is only acted on at the next periodic re-measurement. The replica delay arrives as an input code, and the regulator is modelled as a request/acknowledge pair carrying a voltage code.

Top module: `avs_loop_ctrl`

## Requirements
- R1: After reset, vreg_req, loop_active, loop_locked, at_floor and at_ceiling are 0 and vreg_code is 0.
- R2: A start pulse is ignored (loop_active and vreg_req stay 0) unless sw_enable is high and both a target period (ld_period) and a starting code (ld_vstart) have been loaded since reset.
- R3: On an accepted start, the cycle after the start edge has loop_active=1, vreg_req=1 and vreg_code equal to the starting code clamped into [vmin_code, vmax_code].
- R4: The required delay is period_code minus GUARD (default 8), floored at 0. A measurement above it requests one step up. A measurement below it by more than margin_code requests one step down. A difference from 0 to margin_code inclusive locks the loop (loop_locked=1).
- R5: Each change of vreg_code during a run is at most step_code. While active, the code never leaves [vmin_code, vmax_code], and a step that would cross a limit stops at that limit.
- R6: at_floor is 1 while active with vreg_code equal to vmin_code, and at_ceiling is 1 while active with vreg_code equal to vmax_code.
- R7: vreg_req stays high with a stable code until vreg_ack. After the acknowledge, vreg_req stays low for exactly settle_cycles+2 cycles before the next adjustment request.
- R8: While locked, a measurement above the required delay (code below vmax_code) clears loop_locked and raises vreg_code by one step on the next clock edge.
- R9: While locked, a measurement that is fast by more than the margin has no effect until the relock interval (relock_cycles) has elapsed. The loop then steps down again and relocks.
- R10: Deasserting sw_enable returns the block to idle on the next clock edge, with loop_active and vreg_req at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Loop enable; low forces idle |
| sw_start | input | 1 | Start pulse, accepted from idle |
| ld_period | input | 1 | Load strobe for period_code |
| period_code | input | DW | Target clock period in delay units |
| ld_vstart | input | 1 | Load strobe for vstart_code |
| vstart_code | input | VW | Starting voltage code |
| vmin_code | input | VW | Lowest allowed voltage code |
| vmax_code | input | VW | Highest allowed voltage code |
| step_code | input | VW | Voltage change per adjustment |
| margin_code | input | DW | Width of the lock window |
| settle_cycles | input | CW | Extra wait after regulator acknowledge |
| relock_cycles | input | CW | Re-measure interval while locked |
| meas_delay | input | DW | Measured replica-path delay code |
| vreg_ack | input | 1 | Regulator acknowledge |
| vreg_code | output | VW | Voltage code to the regulator |
| vreg_req | output | 1 | Regulator change request |
| loop_active | output | 1 | Loop is running (not idle) |
| loop_locked | output | 1 | Delay lies inside the margin window |
| at_floor | output | 1 | Active and code at vmin_code |
| at_ceiling | output | 1 | Active and code at vmax_code |

## Verification
The hardest condition to reach is a locked loop whose replica delay then drifts, because it needs a loop that has already converged. The bench models the replica as a delay that falls linearly with the voltage code the regulator has acknowledged, plus an offset it controls. It runs the loop until it locks. It then moves the offset to make the path slow, and checks for the immediate step up on the very next edge. After that it moves the offset to make the path fast, and checks that nothing changes until the relock interval has passed.

// File: rtl/avs_pkg.sv
package avs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_INIT    = 3'd1,
      ST_MEASURE = 3'd2,
      ST_ADJUST  = 3'd3,
      ST_SETTLE  = 3'd4,
      ST_LOCKED  = 3'd5
   } avs_state_e;

   typedef enum logic [1:0] {
      CMP_HOLD  = 2'd0,
      CMP_LOWER = 2'd1,
      CMP_RAISE = 2'd2
   } cmp_dir_e;

endpackage

// File: rtl/avs_target_regs.sv
module avs_target_regs #(
   parameter int DW    = 10,
   parameter int VW    = 8,
   parameter int GUARD = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_period,
   input  logic [DW-1:0] period_in,
   input  logic          ld_vstart,
   input  logic [VW-1:0] vstart_in,
   output logic [DW-1:0] req_delay,
   output logic [VW-1:0] vstart_q,
   output logic          cfg_ready
);
   localparam logic [DW-1:0] GUARD_C = DW'(GUARD);

   logic [DW-1:0] period_q;
   logic          have_period, have_vstart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q    <= '0;
         vstart_q    <= '0;
         have_period <= 1'b0;
         have_vstart <= 1'b0;
      end else begin
         if (ld_period) begin
            period_q    <= period_in;
            have_period <= 1'b1;
         end
         if (ld_vstart) begin
            vstart_q    <= vstart_in;
            have_vstart <= 1'b1;
         end
      end
   end

   assign cfg_ready = have_period && have_vstart;

   generate
      if (GUARD == 0) begin : g_no_guard
         assign req_delay = period_q;
      end else begin : g_guard
         assign req_delay = (period_q > GUARD_C) ? (period_q - GUARD_C) : '0;
      end
   endgenerate

   a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |=> cfg_ready);

endmodule

// File: rtl/avs_delay_cmp.sv
module avs_delay_cmp import avs_pkg::*; #(
   parameter int DW = 10
) (
   input  logic [DW-1:0] req_delay,
   input  logic [DW-1:0] meas_delay,
   input  logic [DW-1:0] margin,
   output cmp_dir_e      dir
);
   logic          too_slow;
   logic [DW-1:0] slack;

   assign too_slow = meas_delay > req_delay;
   assign slack    = req_delay - meas_delay;

   always_comb begin
      if (too_slow)            dir = CMP_RAISE;
      else if (slack > margin) dir = CMP_LOWER;
      else                     dir = CMP_HOLD;
   end

   always_comb begin
      a_r4_window_hold: assert ((dir != CMP_HOLD) ||
         ((meas_delay <= req_delay) && ((req_delay - meas_delay) <= margin)));
   end

endmodule

// File: rtl/avs_step_clamp.sv
module avs_step_clamp import avs_pkg::*; #(
   parameter int VW = 8
) (
   input  logic [VW-1:0] code,
   input  logic [VW-1:0] step,
   input  logic [VW-1:0] vmin,
   input  logic [VW-1:0] vmax,
   input  cmp_dir_e      dir,
   output logic [VW-1:0] next_code,
   output logic          moved
);
   logic [VW:0]   up_sum, low_sum;
   logic [VW-1:0] up_code, down_code;

   assign up_sum    = {1'b0, code} + {1'b0, step};
   assign low_sum   = {1'b0, vmin} + {1'b0, step};
   assign up_code   = (up_sum > {1'b0, vmax}) ? vmax : up_sum[VW-1:0];
   assign down_code = ({1'b0, code} < low_sum) ? vmin : (code - step);

   always_comb begin
      case (dir)
         CMP_RAISE: next_code = up_code;
         CMP_LOWER: next_code = down_code;
         default:   next_code = code;
      endcase
   end

   assign moved = next_code != code;

endmodule

// File: rtl/avs_timer.sv
module avs_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = cnt_q == '0;

   a_r7_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/avs_loop_ctrl.sv
module avs_loop_ctrl import avs_pkg::*; #(
   parameter int VW    = 8,
   parameter int DW    = 10,
   parameter int CW    = 8,
   parameter int GUARD = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_enable,
   input  logic          sw_start,
   input  logic          ld_period,
   input  logic [DW-1:0] period_code,
   input  logic          ld_vstart,
   input  logic [VW-1:0] vstart_code,
   input  logic [VW-1:0] vmin_code,
   input  logic [VW-1:0] vmax_code,
   input  logic [VW-1:0] step_code,
   input  logic [DW-1:0] margin_code,
   input  logic [CW-1:0] settle_cycles,
   input  logic [CW-1:0] relock_cycles,
   input  logic [DW-1:0] meas_delay,
   input  logic          vreg_ack,
   output logic [VW-1:0] vreg_code,
   output logic          vreg_req,
   output logic          loop_active,
   output logic          loop_locked,
   output logic          at_floor,
   output logic          at_ceiling
);
   generate
      if (VW < 4 || DW < 4 || CW < 2 || GUARD < 0) begin : g_bad_cfg
         $error("avs_loop_ctrl: unsupported parameter set");
      end
   endgenerate

   logic [DW-1:0] req_delay;
   logic [VW-1:0] vstart_q, start_code, step_next, code_q, code_d;
   logic          cfg_ready, step_moved, tmr_load, tmr_zero;
   logic [CW-1:0] tmr_val;
   cmp_dir_e      dir;
   avs_state_e    st_q, st_d;

   avs_target_regs #(.DW(DW), .VW(VW), .GUARD(GUARD)) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .ld_period(ld_period), .period_in(period_code),
      .ld_vstart(ld_vstart), .vstart_in(vstart_code),
      .req_delay(req_delay), .vstart_q(vstart_q), .cfg_ready(cfg_ready));

   avs_delay_cmp #(.DW(DW)) u_cmp (
      .req_delay(req_delay), .meas_delay(meas_delay),
      .margin(margin_code), .dir(dir));

   avs_step_clamp #(.VW(VW)) u_step (
      .code(code_q), .step(step_code), .vmin(vmin_code), .vmax(vmax_code),
      .dir(dir), .next_code(step_next), .moved(step_moved));

   avs_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .zero(tmr_zero));

   assign start_code = (vstart_q < vmin_code) ? vmin_code :
                       (vstart_q > vmax_code) ? vmax_code : vstart_q;

   always_comb begin
      st_d     = st_q;
      code_d   = code_q;
      tmr_load = 1'b0;
      tmr_val  = settle_cycles;
      case (st_q)
         ST_IDLE: begin
            if (sw_enable && sw_start && cfg_ready) begin
               st_d   = ST_INIT;
               code_d = start_code;
            end
         end
         ST_INIT, ST_ADJUST: begin
            if (vreg_ack) begin
               st_d     = ST_SETTLE;
               tmr_load = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (tmr_zero) st_d = ST_MEASURE;
         end
         ST_MEASURE: begin
            if (dir == CMP_HOLD) begin
               st_d     = ST_LOCKED;
               tmr_load = 1'b1;
               tmr_val  = relock_cycles;
            end else if (step_moved) begin
               st_d   = ST_ADJUST;
               code_d = step_next;
            end else begin
               st_d     = ST_SETTLE;
               tmr_load = 1'b1;
            end
         end
         ST_LOCKED: begin
            if (dir == CMP_RAISE && step_moved) begin
               st_d   = ST_ADJUST;
               code_d = step_next;
            end else if (tmr_zero) begin
               st_d = ST_MEASURE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (!sw_enable) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         code_q <= '0;
      end else begin
         st_q   <= st_d;
         code_q <= code_d;
      end
   end

   assign vreg_code   = code_q;
   assign vreg_req    = (st_q == ST_INIT) || (st_q == ST_ADJUST);
   assign loop_active = st_q != ST_IDLE;
   assign loop_locked = st_q == ST_LOCKED;
   assign at_floor    = loop_active && (code_q == vmin_code);
   assign at_ceiling  = loop_active && (code_q == vmax_code);

   a_r2_needs_config: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ready |-> !loop_active);

   a_r3_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_active) |-> (vreg_req && vreg_code >= vmin_code && vreg_code <= vmax_code));

   a_r4_lock_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_locked) |-> $past((meas_delay <= req_delay) &&
                                   ((req_delay - meas_delay) <= margin_code)));

   a_r5_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && $past(loop_active)) |->
         ((vreg_code >= $past(vreg_code)) ? ((vreg_code - $past(vreg_code)) <= step_code)
                                          : (($past(vreg_code) - vreg_code) <= step_code)));

   a_r5_within_limits: assert property (@(posedge clk) disable iff (!rst_n)
      loop_active |-> (vreg_code >= vmin_code && vreg_code <= vmax_code));

   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (vreg_req && !vreg_ack && sw_enable) |=> (vreg_req && $stable(vreg_code)));

   a_r8_slow_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_locked && sw_enable && meas_delay > req_delay && vreg_code != vmax_code)
         |=> (!loop_locked && vreg_req));

   a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_enable |=> (!loop_active && !vreg_req));

endmodule

// File: tb/avs_loop_ctrl_bench.sv
module avs_loop_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 8, DW = 10, CW = 8;
   localparam int SETTLE = 5;

   // stimulus: period, vstart, vmin, vmax, step, margin; expected: code, locked, floor, ceiling
   typedef struct packed {
      logic [9:0] period; logic [7:0] vstart; logic [7:0] vmin; logic [7:0] vmax;
      logic [7:0] step;   logic [9:0] margin; logic [7:0] exp_code;
      logic exp_lock; logic exp_floor; logic exp_ceil;
   } vec_t;
   localparam int NVEC = 5;
   localparam vec_t VEC [NVEC] = '{
      '{10'd208, 8'd180, 8'd20,  8'd240, 8'd4, 10'd10, 8'd104, 1'b1, 1'b0, 1'b0},
      '{10'd208, 8'd180, 8'd150, 8'd240, 8'd4, 10'd10, 8'd150, 1'b0, 1'b1, 1'b0},
      '{10'd208, 8'd60,  8'd20,  8'd240, 8'd4, 10'd10, 8'd100, 1'b1, 1'b0, 1'b0},
      '{10'd208, 8'd250, 8'd20,  8'd200, 8'd8, 10'd20, 8'd104, 1'b1, 1'b0, 1'b0},
      '{10'd108, 8'd100, 8'd20,  8'd120, 8'd4, 10'd10, 8'd120, 1'b0, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sw_enable = 1'b0, sw_start = 1'b0, ld_period = 1'b0, ld_vstart = 1'b0;
   logic [DW-1:0] period_code = '0, margin_code = '0, meas_delay;
   logic [VW-1:0] vstart_code = '0, vmin_code = '0, vmax_code = '0, step_code = '0;
   logic [CW-1:0] settle_cycles = CW'(SETTLE), relock_cycles = 8'd40;
   logic          vreg_ack;
   logic [VW-1:0] vreg_code, applied;
   logic          vreg_req, loop_active, loop_locked, at_floor, at_ceiling;
   int            delay_off = 0;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   avs_loop_ctrl u_avs_loop_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .sw_start(sw_start),
      .ld_period(ld_period), .period_code(period_code), .ld_vstart(ld_vstart),
      .vstart_code(vstart_code), .vmin_code(vmin_code), .vmax_code(vmax_code),
      .step_code(step_code), .margin_code(margin_code), .settle_cycles(settle_cycles),
      .relock_cycles(relock_cycles), .meas_delay(meas_delay), .vreg_ack(vreg_ack),
      .vreg_code(vreg_code), .vreg_req(vreg_req), .loop_active(loop_active),
      .loop_locked(loop_locked), .at_floor(at_floor), .at_ceiling(at_ceiling));

   // regulator: one-cycle acknowledge pulse, voltage applied when accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vreg_ack <= 1'b0;
         applied  <= '0;
      end else begin
         vreg_ack <= vreg_req && !vreg_ack;
         if (vreg_req && vreg_ack) applied <= vreg_code;
      end
   end

   // replica path: higher voltage code gives a shorter delay
   always_comb begin
      int d;
      d = 400 - 2 * int'(applied) + delay_off;
      if (d < 0) d = 0;
      if (d > 1023) d = 1023;
      meas_delay = DW'(d);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic start_vec(input int i);
      int clamp_exp;
      sw_enable = 1'b0;
      cycles(2);
      period_code = VEC[i].period; vstart_code = VEC[i].vstart;
      vmin_code = VEC[i].vmin; vmax_code = VEC[i].vmax;
      step_code = VEC[i].step; margin_code = VEC[i].margin;
      ld_period = 1'b1; ld_vstart = 1'b1;
      cycles(1);
      ld_period = 1'b0; ld_vstart = 1'b0; sw_enable = 1'b1; sw_start = 1'b1;
      cycles(1);
      sw_start = 1'b0;
      clamp_exp = (VEC[i].vstart < VEC[i].vmin) ? int'(VEC[i].vmin) :
                  (VEC[i].vstart > VEC[i].vmax) ? int'(VEC[i].vmax) : int'(VEC[i].vstart);
      chk(loop_active && vreg_req, "R3 start request", int'(vreg_req), 1);
      chk(int'(vreg_code) == clamp_exp, "R3 clamped start code", int'(vreg_code), clamp_exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      cycles(3);
      // R1 reset state
      chk(vreg_req == 1'b0 && loop_active == 1'b0, "R1 req/active", int'(vreg_req), 0);
      chk(loop_locked == 1'b0, "R1 locked", int'(loop_locked), 0);
      chk(at_floor == 1'b0 && at_ceiling == 1'b0, "R1 flags", int'(at_floor), 0);
      chk(vreg_code == '0, "R1 code", int'(vreg_code), 0);
      rst_n = 1'b1;
      cycles(2);

      // R2 start without a loaded starting code
      period_code = 10'd208; ld_period = 1'b1;
      cycles(1);
      ld_period = 1'b0; sw_enable = 1'b1; sw_start = 1'b1;
      cycles(1);
      sw_start = 1'b0;
      for (int k = 0; k < 10; k++) begin
         chk(!loop_active && !vreg_req, "R2 start ignored", int'(loop_active), 0);
         cycles(1);
      end

      // vector table: convergence, limits and flags
      for (int i = 0; i < NVEC; i++) begin
         start_vec(i);
         cycles(1500);
         chk(vreg_code == VEC[i].exp_code, "R4 R5 final code", int'(vreg_code), int'(VEC[i].exp_code));
         chk(loop_locked == VEC[i].exp_lock, "R4 lock state", int'(loop_locked), int'(VEC[i].exp_lock));
         chk(at_floor == VEC[i].exp_floor, "R6 floor flag", int'(at_floor), int'(VEC[i].exp_floor));
         chk(at_ceiling == VEC[i].exp_ceil, "R6 ceiling flag", int'(at_ceiling), int'(VEC[i].exp_ceil));
      end

      // R7 request gap after acknowledge
      begin
         int gap = 0;
         int guard = 0;
         start_vec(0);
         while (vreg_req && guard < 50) begin cycles(1); guard++; end
         while (!vreg_req && guard < 100) begin gap++; cycles(1); guard++; end
         chk(gap == SETTLE + 2, "R7 settle gap", gap, SETTLE + 2);
         chk(vreg_code == 8'd176, "R5 one step down", int'(vreg_code), 176);
      end
      cycles(1500);
      chk(loop_locked && vreg_code == 8'd104, "R4 relocked at 104", int'(vreg_code), 104);

      // R8 slow drift while locked: immediate step up
      delay_off = 20;
      cycles(1);
      chk(!loop_locked, "R8 lock dropped", int'(loop_locked), 0);
      chk(vreg_code == 8'd108, "R8 immediate step up", int'(vreg_code), 108);
      cycles(1500);
      chk(loop_locked && vreg_code == 8'd112, "R8 relock code", int'(vreg_code), 112);

      // R9 fast drift while locked: waits for relock interval
      delay_off = -30;
      cycles(5);
      chk(loop_locked, "R9 still locked", int'(loop_locked), 1);
      chk(vreg_code == 8'd112, "R9 code held", int'(vreg_code), 112);
      cycles(1500);
      chk(loop_locked && vreg_code == 8'd88, "R9 lower relock", int'(vreg_code), 88);

      // R10 disable mid-descent
      delay_off = 0;
      start_vec(0);
      cycles(30);
      sw_enable = 1'b0;
      cycles(1);
      chk(!loop_active && !vreg_req, "R10 disable to idle", int'(loop_active), 0);
      chk(!loop_locked, "R10 not locked", int'(loop_locked), 0);

      finish_run();
   end

endmodule